// File: doc/BRIEF.md
# Single-Price Drink Vending Controller

This controller runs a machine that sells eight kinds of drink, all at one fixed price. While idle it waits for a payment. A payment arrives as a pulse on the money input, and the controller reacts to the rising edge of that pulse. After a payment it lights eight LEDs that show the live stock vector, so the customer can see which drinks are available.

The customer then sets exactly one of eight selection switches. The controller captures that choice and drives the matching dispense line. It holds the line until the delivery mechanism sends its acknowledge, and then it goes back to waiting for money. Stock is shown for information only and never blocks a sale. Change, multiple coins and refunds are left to other logic.

Top module: `vend_ctrl`

## Requirements
- R1: An active-high reset, applied at any time and without waiting for a clock edge, puts the controller in the idle (waiting-for-money) state with both output vectors at zero.
- R2: In the idle state, a rising edge on `money_in` (0 in one cycle, 1 in the next) moves the controller to the stock-display state on that clock edge. A money level held high counts as a single payment, so staying high after a sale does not start a new one.
- R3: In the idle state, `led_out` and `drink_out` are both all zeros.
- R4: In the stock-display state, `led_out` equals `stock_in` bit for bit (bit i at 1 means drink i is available), and `drink_out` is zero.
- R5: In the stock-display state, a clock edge with exactly one bit of `pick_in` set moves the controller to the dispensing state, where bit i selects drink i. Every other pattern, including all zeros and two or more bits set, leaves the controller in stock-display.
- R6: In the dispensing state, `drink_out` holds the one-hot selection captured on entry and `led_out` is zero. Changes on `pick_in` during dispensing have no effect on `drink_out`.
- R7: In the dispensing state, a clock edge with `delivered_in` high returns the controller to idle. When the controller is not dispensing, `delivered_in` has no effect.
- R8: A rising edge on `money_in` while the controller is in stock-display or dispensing has no effect on the state or the outputs.
- R9: A selection is accepted whether or not the stock bit for that drink is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, active high, asynchronous |
| money_in | input | 1 | Payment pulse |
| stock_in | input | 8 | Availability of each drink, 1 = in stock |
| pick_in | input | 8 | One-hot drink selection switches |
| delivered_in | input | 1 | Acknowledge from the mechanism that the drink was delivered |
| led_out | output | 8 | Stock display, driven only in stock-display |
| drink_out | output | 8 | One-hot dispense lines, driven only while dispensing |

## Verification
The bench targets these failure cases:
- A money level held high across a whole sale. A design that tests the level instead of the edge would start a second sale with no new payment.
- Selection patterns with zero bits or two bits set. A design with a loose one-hot test would dispense a blend of drinks, or nothing at all.
- Switch changes and new money pulses during dispensing. A design that follows the switches live would change the drink in mid-delivery.
- An acknowledge that arrives while idle. A design that acts on it would leave idle without a payment.
- A selection for a drink that is out of stock. A design that gates on stock would refuse it.
- A reset in mid-dispense. It must clear the dispense line at once, without waiting for a clock edge.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int unsigned N_DRINKS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOW = 2'd1,
        ST_DISP = 2'd2
    } vend_state_e;

    typedef struct packed {
        vend_state_e               st;
        logic [N_DRINKS-1:0]       pick_q;
    } vend_regs_t;

    function automatic logic exactly_one(input logic [N_DRINKS-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < N_DRINKS; i++) begin
            n += int'(v[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/vend_pay_edge.sv
module vend_pay_edge (
    input  logic clk,
    input  logic rst,
    input  logic money,
    output logic pay_rise
);
    logic money_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) money_q <= 1'b0;
        else     money_q <= money;
    end

    assign pay_rise = money & ~money_q;

    // A rise cannot be seen two cycles running (R2)
    p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
        pay_rise |=> !pay_rise);
endmodule

// File: rtl/vend_sel_check.sv
module vend_sel_check
    import vend_pkg::*;
(
    input  logic [N_DRINKS-1:0] pick,
    output logic                sel_ok
);
    assign sel_ok = exactly_one(pick);

    always_comb begin
        // An accepted pattern carries exactly one bit (R5)
        p_sel_onehot_r5: assert (!sel_ok || $onehot(pick));
    end
endmodule

// File: rtl/vend_fsm_core.sv
module vend_fsm_core
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pay_rise,
    input  logic                sel_ok,
    input  logic                delivered,
    input  logic [N_DRINKS-1:0] pick,
    input  logic [N_DRINKS-1:0] stock,
    output logic [N_DRINKS-1:0] led,
    output logic [N_DRINKS-1:0] drink
);
    vend_regs_t r, r_nxt;

    always_comb begin
        r_nxt = r;
        unique case (r.st)
            ST_IDLE: if (pay_rise) r_nxt.st = ST_SHOW;
            ST_SHOW: if (sel_ok) begin
                r_nxt.st     = ST_DISP;
                r_nxt.pick_q = pick;
            end
            ST_DISP: if (delivered) begin
                r_nxt.st     = ST_IDLE;
                r_nxt.pick_q = '0;
            end
            default: r_nxt = '{st: ST_IDLE, pick_q: '0};
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r <= '{st: ST_IDLE, pick_q: '0};
        else     r <= r_nxt;
    end

    assign led   = (r.st == ST_SHOW) ? stock    : '0;
    assign drink = (r.st == ST_DISP) ? r.pick_q : '0;

    p_pay_enters_show_r2: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_IDLE && pay_rise) |=> (r.st == ST_SHOW));
    p_idle_needs_pay_r7: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_IDLE && !pay_rise) |=> (r.st == ST_IDLE));
    p_bad_sel_stays_r5: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_SHOW && !sel_ok) |=> (r.st == ST_SHOW));
    p_disp_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_DISP) |-> ($countones(drink) == 1));
    p_disp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_DISP && !delivered) |=> (r.st == ST_DISP && $stable(drink)));
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (r.st == ST_DISP && delivered) |=> (r.st == ST_IDLE));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                money_in,
    input  logic [N_DRINKS-1:0] stock_in,
    input  logic [N_DRINKS-1:0] pick_in,
    input  logic                delivered_in,
    output logic [N_DRINKS-1:0] led_out,
    output logic [N_DRINKS-1:0] drink_out
);
    logic pay_rise;
    logic sel_ok;

    vend_pay_edge i_pay (
        .clk      (clk),
        .rst      (rst),
        .money    (money_in),
        .pay_rise (pay_rise)
    );

    vend_sel_check i_sel (
        .pick   (pick_in),
        .sel_ok (sel_ok)
    );

    vend_fsm_core i_core (
        .clk       (clk),
        .rst       (rst),
        .pay_rise  (pay_rise),
        .sel_ok    (sel_ok),
        .delivered (delivered_in),
        .pick      (pick_in),
        .stock     (stock_in),
        .led       (led_out),
        .drink     (drink_out)
    );

    // The two output groups are never active together (R4, R6)
    p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(|led_out && |drink_out));
endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       money_in = 1'b0;
    logic [7:0] stock_in = '0;
    logic [7:0] pick_in = '0;
    logic       delivered_in = 1'b0;
    logic [7:0] led_out, drink_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state: 0 idle, 1 show, 2 dispense
    int         m_st = 0;
    logic [7:0] m_drink = '0;
    logic       m_prev = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    vend_ctrl i_vend_ctrl (
        .clk(clk), .rst(rst), .money_in(money_in), .stock_in(stock_in),
        .pick_in(pick_in), .delivered_in(delivered_in),
        .led_out(led_out), .drink_out(drink_out)
    );

    function automatic bit one_set(input logic [7:0] v);
        return $countones(v) == 1;
    endfunction

    function automatic logic [7:0] exp_led(input int st, input logic [7:0] s);
        return (st == 1) ? s : 8'h00;
    endfunction

    function automatic logic [7:0] exp_drink(input int st, input logic [7:0] d);
        return (st == 2) ? d : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clock(input logic m, input logic [7:0] p, input logic d);
        logic rise;
        rise = m & ~m_prev;
        m_prev = m;
        case (m_st)
            0: if (rise) m_st = 1;
            1: if (one_set(p)) begin m_st = 2; m_drink = p; end
            default: if (d) begin m_st = 0; m_drink = '0; end
        endcase
    endtask

    task automatic step(input logic m, input logic [7:0] s, input logic [7:0] p,
                        input logic d, input string tag);
        @(negedge clk);
        money_in = m; stock_in = s; pick_in = p; delivered_in = d;
        @(posedge clk);
        model_clock(m, p, d);
        #1;
        chk({tag, " led"},   led_out,   exp_led(m_st, s));
        chk({tag, " drink"}, drink_out, exp_drink(m_st, m_drink));
    endtask

    function automatic string st_tag(input int st);
        return (st == 0) ? "R3" : (st == 1) ? "R4" : "R6";
    endfunction

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd4711);
        rst = 1'b1;
        #9;
        chk("R1 reset led", led_out, 8'h00);
        chk("R1 reset drink", drink_out, 8'h00);
        @(negedge clk); rst = 1'b0;
        m_st = 0; m_prev = 1'b0; m_drink = '0;

        // directed: long money pulse, bad picks, out-of-stock pick
        step(1'b0, 8'hF7, 8'h00, 1'b1, "R7 ack while idle");
        step(1'b1, 8'hF7, 8'h00, 1'b0, "R2 rise");
        step(1'b1, 8'hF7, 8'h09, 1'b0, "R5 two bits");
        step(1'b1, 8'h5A, 8'h00, 1'b0, "R5 zero pick");
        step(1'b1, 8'hF7, 8'h08, 1'b0, "R9 out-of-stock pick");
        step(1'b0, 8'hFF, 8'h20, 1'b0, "R6 switch change");
        step(1'b1, 8'hFF, 8'h21, 1'b0, "R8 money in dispense");
        step(1'b1, 8'hFF, 8'h00, 1'b1, "R7 release");
        step(1'b1, 8'hFF, 8'h00, 1'b0, "R2 held level");
        step(1'b1, 8'hFF, 8'h00, 1'b1, "R7 ack idle");
        step(1'b0, 8'hFF, 8'h00, 1'b0, "R3 idle");
        step(1'b1, 8'h3C, 8'h00, 1'b0, "R2 second rise");
        step(1'b0, 8'h3C, 8'h00, 1'b0, "R4 show");
        step(1'b1, 8'h3C, 8'h00, 1'b0, "R8 money in show");
        step(1'b0, 8'h3C, 8'h80, 1'b0, "R5 pick bit7");
        step(1'b0, 8'h3C, 8'h01, 1'b0, "R6 hold");

        // asynchronous reset in mid-dispense
        @(negedge clk); #0.5;
        rst = 1'b1;
        #0.5;
        chk("R1 async drink", drink_out, 8'h00);
        chk("R1 async led", led_out, 8'h00);
        @(negedge clk); rst = 1'b0; money_in = 1'b0;
        m_st = 0; m_prev = 1'b0; m_drink = '0;

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic m, d;
            logic [7:0] s, p;
            m = ($urandom % 4) == 0;
            d = ($urandom % 5) == 0;
            s = 8'($urandom);
            p = (($urandom % 2) == 0) ? 8'(1 << ($urandom % 8)) : 8'($urandom);
            step(m, s, p, d, st_tag(m_st));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule